// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Target

This block is a synchronous slave on a 16-bit external bus whose lines carry an address first and then data. The host supplies a free-running bus clock, which is the block's only clock. In the address phase the host drives the address with address-valid and chip-select active, and the block latches it. A write places the data word on the same lines in the next phase, and the block stores it in a small register file. A read fetches the addressed word after a configured number of wait cycles and drives it onto the lines.

The drive enable is a single register that follows the host's output-enable with one clock of delay. After the host releases chip-select or output-enable, the block therefore keeps driving for one more cycle and then goes high impedance. The host must add one read wait state to allow for this, and it must not drive the lines again until that extra cycle is over.

The controller is a four-state machine:

- `ST_IDLE`: waits for an address phase.
- `ST_WR_DATA`: waits for the write data.
- `ST_RD_WAIT`: counts read wait cycles.
- `ST_RD_DRIVE`: presents the read word.

Its transitions are:

- `ADDR_WR` (`ST_IDLE` to `ST_WR_DATA`)
- `ADDR_RD` (`ST_IDLE` to `ST_RD_WAIT`)
- `WR_COMMIT` (`ST_WR_DATA` to `ST_IDLE`)
- `WAIT_DONE` (`ST_RD_WAIT` to `ST_RD_DRIVE`)
- `CS_DROP` (any state to `ST_IDLE` when chip-select is high)

Top module: `muxbus_slave`

## Requirements
- R1: On a rising edge in `ST_IDLE` with `cs_n` and `adv_n` both low, the block latches `ad_in`. The low log2(REG_DEPTH) bits select the register, so with depth 16, address 0x0025 and address 0x0005 name the same word.
- R2: A write has an address edge with `we_n` low, then a data edge with `cs_n` low, `we_n` low and `adv_n` high; `ad_in` at the data edge is stored. If `cs_n` is high at the data edge, nothing is stored. All registers read as 0 after reset.
- R3: In a read (`we_n` high at the address edge), `ad_oe` is low after the first RD_WAIT-1 edges following the address edge. With `cs_n` and `oe_n` low, it is high after the RD_WAIT-th edge (3 by default, the nominal 2 plus 1), and `ad_out` then carries the addressed word.
- R4: `ad_oe` is a register set only by an edge at which `cs_n` and `oe_n` were both low. If `oe_n` is held high through the wait, nothing is driven, and driving starts one edge after `oe_n` falls.
- R5: After the first edge that sees `cs_n` or `oe_n` high, `ad_oe` is low. Until that edge it stays high, which gives one cycle of drive after the host releases.
- R6: `ad_oe` and `ad_out` are 0 in reset, in idle, during the address phase and throughout a write.
- R7: `cs_n` going high during the read wait returns the block to idle with no drive, and the next transaction proceeds normally.
- R8: With a host that follows the stretched turnaround, at no time do the host and the block drive the lines together.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running bus clock from the host |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Chip-select, active low |
| adv_n | input | 1 | Address-valid, active low |
| we_n | input | 1 | Write-enable, active low |
| oe_n | input | 1 | Host output-enable, active low |
| ad_in | input | DATA_W | Value seen on the shared lines |
| ad_out | output | DATA_W | Read data toward the line drivers (0 when not driving) |
| ad_oe | output | 1 | Registered drive enable for the shared lines |

## Verification
A controller stuck in the wrong state shows at the ports within one edge. Examples are a read wait that ends early, or a write taken for a read: `ad_oe` rises before the RD_WAIT-th edge, or while the host still owns the lines. A wrong latched index or a lost write does not show until the word is read back. Reads are therefore placed after every write, including aliased and aborted ones. A drive enable that drops one cycle early, or that lingers, is caught at the edge after release by sampling `ad_oe` on both clock phases.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WR_DATA,
        ST_RD_WAIT,
        ST_RD_DRIVE
    } bus_state_t;

endpackage

// File: rtl/muxbus_regfile.sv
module muxbus_regfile #(
    parameter int DATA_W    = 16,
    parameter int REG_DEPTH = 16,
    localparam int IDX_W    = $clog2(REG_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] mem_q [REG_DEPTH];

    for (genvar g = 0; g < REG_DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                mem_q[g] <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                mem_q[g] <= wr_data;
            end
        end
    end

    assign rd_data = mem_q[rd_idx];

endmodule

// File: rtl/muxbus_ctrl.sv
module muxbus_ctrl
    import muxbus_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int IDX_W   = 4,
    parameter int RD_WAIT = 3,
    localparam int CNT_W  = $clog2(RD_WAIT + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] ad_in,
    output logic [IDX_W-1:0]  idx_q,
    output logic              wr_fire,
    output logic [DATA_W-1:0] wr_data,
    output logic              rd_load,
    output logic              drive_next,
    output logic              hold_next,
    output bus_state_t        state_q
);

    bus_state_t state_d;
    logic [CNT_W-1:0] wait_q;
    logic addr_edge;

    assign addr_edge = !cs_n && !adv_n;

    // state register, index latch and wait counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
            wait_q  <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && addr_edge) begin
                idx_q <= ad_in[IDX_W-1:0];
            end
            if (state_q == ST_RD_WAIT && state_d == ST_RD_WAIT) begin
                wait_q <= wait_q + 1'b1;
            end else begin
                wait_q <= '0;
            end
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (addr_edge) begin
                    state_d = we_n ? ST_RD_WAIT : ST_WR_DATA;   // ADDR_RD / ADDR_WR
                end
            end
            ST_WR_DATA: begin
                if (cs_n) begin
                    state_d = ST_IDLE;                          // CS_DROP
                end else if (!we_n && adv_n) begin
                    state_d = ST_IDLE;                          // WR_COMMIT
                end
            end
            ST_RD_WAIT: begin
                if (cs_n) begin
                    state_d = ST_IDLE;                          // CS_DROP
                end else if (wait_q == CNT_W'(RD_WAIT - 1)) begin
                    state_d = ST_RD_DRIVE;                      // WAIT_DONE
                end
            end
            ST_RD_DRIVE: begin
                if (cs_n) begin
                    state_d = ST_IDLE;                          // CS_DROP
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // output decode
    always_comb begin
        wr_fire    = (state_q == ST_WR_DATA) && !cs_n && !we_n && adv_n;
        wr_data    = ad_in;
        rd_load    = (state_q == ST_RD_WAIT) && (state_d == ST_RD_DRIVE);
        hold_next  = (state_d == ST_RD_DRIVE);
        drive_next = hold_next && !cs_n && !oe_n;
    end

endmodule

// File: rtl/muxbus_drive.sv
module muxbus_drive #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_load,
    input  logic              hold_next,
    input  logic              drive_next,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);

    logic [DATA_W-1:0] data_q;
    logic              oe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            oe_q   <= 1'b0;
        end else begin
            oe_q <= drive_next;
            if (rd_load) begin
                data_q <= rf_rdata;
            end else if (!hold_next) begin
                data_q <= '0;
            end
        end
    end

    assign ad_oe  = oe_q;
    assign ad_out = oe_q ? data_q : '0;

endmodule

// File: rtl/muxbus_slave.sv
module muxbus_slave
    import muxbus_pkg::*;
#(
    parameter int DATA_W    = 16,
    parameter int REG_DEPTH = 16,
    parameter int RD_WAIT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              adv_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [DATA_W-1:0] ad_in,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe
);

    localparam int IDX_W = $clog2(REG_DEPTH);

    logic [IDX_W-1:0]  idx_q;
    logic              wr_fire;
    logic [DATA_W-1:0] wr_data;
    logic              rd_load;
    logic              drive_next;
    logic              hold_next;
    logic [DATA_W-1:0] rf_rdata;
    bus_state_t        state_q;

    muxbus_ctrl #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W),
        .RD_WAIT(RD_WAIT)
    ) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .adv_n     (adv_n),
        .we_n      (we_n),
        .oe_n      (oe_n),
        .ad_in     (ad_in),
        .idx_q     (idx_q),
        .wr_fire   (wr_fire),
        .wr_data   (wr_data),
        .rd_load   (rd_load),
        .drive_next(drive_next),
        .hold_next (hold_next),
        .state_q   (state_q)
    );

    muxbus_regfile #(
        .DATA_W   (DATA_W),
        .REG_DEPTH(REG_DEPTH)
    ) rf_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_fire),
        .wr_idx (idx_q),
        .wr_data(wr_data),
        .rd_idx (idx_q),
        .rd_data(rf_rdata)
    );

    muxbus_drive #(
        .DATA_W(DATA_W)
    ) drv_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_load   (rd_load),
        .hold_next (hold_next),
        .drive_next(drive_next),
        .rf_rdata  (rf_rdata),
        .ad_out    (ad_out),
        .ad_oe     (ad_oe)
    );

endmodule

// File: rtl/muxbus_slave_chk.sv
module muxbus_slave_chk
    import muxbus_pkg::*;
#(
    parameter int RD_WAIT = 3
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       adv_n,
    input logic       oe_n,
    input logic       ad_oe,
    input bus_state_t state_q
);

    logic [7:0] since_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_q <= '0;
        end else if (!cs_n && !adv_n) begin
            since_q <= '0;
        end else if (since_q != 8'hFF) begin
            since_q <= since_q + 8'd1;
        end
    end

    // R4: drive only follows an edge that saw chip-select and output-enable low
    a_r4_oe_delayed: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe |-> $past(!cs_n && !oe_n));

    // R5: drive ends one edge after the host releases
    a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ad_oe && (cs_n || oe_n)) |=> !ad_oe);

    // R6: an address phase taken in idle is never followed by drive
    a_r6_addr_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !cs_n && !adv_n) |=> !ad_oe);

    // R6: no drive while a write is in progress
    a_r6_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WR_DATA) |-> !ad_oe);

    // R3: drive never starts before the configured wait has elapsed
    a_r3_wait_met: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ad_oe) |-> (since_q >= 8'(RD_WAIT)));

endmodule

bind muxbus_slave muxbus_slave_chk #(.RD_WAIT(RD_WAIT)) chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .cs_n   (cs_n),
    .adv_n  (adv_n),
    .oe_n   (oe_n),
    .ad_oe  (ad_oe),
    .state_q(state_q)
);

// File: tb/muxbus_slave_tb_top.sv
module muxbus_slave_tb_top;

    localparam int DATA_W  = 16;
    localparam int RD_WAIT = 3;
    localparam time CLK_P  = 4ns;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, adv_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic host_drv = 1'b0;
    logic [DATA_W-1:0] host_val = '0;
    logic [DATA_W-1:0] ad_in;
    logic [DATA_W-1:0] ad_out;
    logic ad_oe;

    int checks = 0;
    int errors = 0;
    int clash  = 0;
    bit done   = 0;

    always #(CLK_P / 2) clk = ~clk;

    assign ad_in = host_drv ? host_val : (ad_oe ? ad_out : '0);

    muxbus_slave #(.DATA_W(DATA_W), .REG_DEPTH(16), .RD_WAIT(RD_WAIT)) dut_i (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .adv_n(adv_n), .we_n(we_n),
        .oe_n(oe_n), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe)
    );

    // R8: both sides driving at once, sampled on both clock phases
    always @(clk) begin
        #1;
        if (rst_n && host_drv && ad_oe) clash++;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic addr_phase(input logic [DATA_W-1:0] a, input logic wr);
        @(negedge clk);
        cs_n = 0; adv_n = 0; we_n = !wr; oe_n = 1; host_drv = 1; host_val = a;
    endtask

    task automatic bus_write(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] d);
        addr_phase(a, 1'b1);
        @(negedge clk);
        adv_n = 1; host_val = d;
        @(posedge clk); #1;
        chk(ad_oe == 0, "R6 write no drive", ad_oe, 0);
        @(negedge clk);
        cs_n = 1; we_n = 1; host_drv = 0;
    endtask

    task automatic bus_read(input logic [DATA_W-1:0] a, input logic [DATA_W-1:0] exp);
        addr_phase(a, 1'b0);
        @(negedge clk);
        adv_n = 1; host_drv = 0; oe_n = 0;
        for (int k = 1; k <= RD_WAIT; k++) begin
            @(posedge clk); #1;
            if (k < RD_WAIT) chk(ad_oe == 0, "R3 early drive", ad_oe, 0);
            else begin
                chk(ad_oe == 1, "R3 drive on time", ad_oe, 1);
                chk(ad_out == exp, "R3/R1/R2 read data", ad_out, exp);
            end
        end
        @(posedge clk);
        @(negedge clk);
        cs_n = 1; oe_n = 1;
        #1 chk(ad_oe == 1, "R5 extra drive cycle", ad_oe, 1);
        @(posedge clk); #1;
        chk(ad_oe == 0, "R5 released", ad_oe, 0);
        chk(ad_out == 0, "R6 idle output", ad_out, 0);
    endtask

    task automatic t_reset;
        #1 chk(ad_oe == 0 && ad_out == 0, "R6 reset state", {ad_oe, ad_out}, 0);
        bus_read(16'h0007, 16'h0000);   // R2 reset contents
    endtask

    task automatic t_basic;
        bus_write(16'h0001, 16'hA5C3);
        bus_write(16'h0002, 16'h1234);
        bus_write(16'h000F, 16'hFFFF);
        bus_read(16'h0002, 16'h1234);
        bus_read(16'h0001, 16'hA5C3);
        bus_read(16'h000F, 16'hFFFF);
    endtask

    task automatic t_alias;
        bus_write(16'h0025, 16'hBEEF);  // R1 upper bits ignored
        bus_read(16'h0005, 16'hBEEF);
    endtask

    task automatic t_write_abort;
        addr_phase(16'h0001, 1'b1);
        @(negedge clk);
        adv_n = 1; cs_n = 1; host_val = 16'h0BAD;
        @(negedge clk);
        we_n = 1; host_drv = 0;
        bus_read(16'h0001, 16'hA5C3);   // R2 aborted write not stored
    endtask

    task automatic t_read_abort;
        addr_phase(16'h0002, 1'b0);
        @(negedge clk);
        adv_n = 1; host_drv = 0; oe_n = 0;
        @(negedge clk);
        cs_n = 1; oe_n = 1;
        for (int k = 0; k < RD_WAIT + 2; k++) begin
            @(posedge clk); #1;
            chk(ad_oe == 0, "R7 aborted read silent", ad_oe, 0);
        end
        bus_read(16'h0002, 16'h1234);   // R7 recovers
    endtask

    task automatic t_oe_gate;
        addr_phase(16'h000F, 1'b0);
        @(negedge clk);
        adv_n = 1; host_drv = 0;
        for (int k = 0; k < RD_WAIT + 1; k++) begin
            @(posedge clk); #1;
            chk(ad_oe == 0, "R4 no drive while oe_n high", ad_oe, 0);
        end
        @(negedge clk);
        oe_n = 0;
        #1 chk(ad_oe == 0, "R4 one clock delay", ad_oe, 0);
        @(posedge clk); #1;
        chk(ad_oe == 1 && ad_out == 16'hFFFF, "R4 drive after oe_n", ad_out, 16'hFFFF);
        @(negedge clk);
        oe_n = 1;
        @(posedge clk); #1;
        chk(ad_oe == 0, "R5 oe_n release alone", ad_oe, 0);
        @(negedge clk);
        cs_n = 1;
    endtask

    initial begin
        #(CLK_P * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog expired");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_basic();
        t_alias();
        t_write_abort();
        t_read_abort();
        t_oe_gate();
        repeat (2) @(negedge clk);
        chk(clash == 0, "R8 bus contention cycles", clash, 0);
        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule